// File: doc/BRIEF.md
# Stop-Clock Low-Power State Controller

This controller moves a processor between normal execution and a stop-grant low-power state. System logic starts entry by pulling an asynchronous, active-low stop request. The controller first resynchronises that request to the bus clock. It then raises an acknowledge-transaction request to the bus interface and holds it until the bus interface reports that the transaction has gone out. Only after that does it drop the clock enables of the core units. The enables for the bus interface and the interrupt controller stay high the whole time, so snooping and interrupt service carry on while the core is stopped. The request has no effect on the bus clock itself.

When the stop request is released, the controller turns every core clock enable back on at once. It then waits a short, configurable settling window and pulses a resume signal, which tells the core that execution may continue. A request that is withdrawn while the acknowledge is still pending does not abort the transaction. The acknowledge completes, and the controller then returns straight to normal running without ever stopping the core clocks. A two-bit status output reports the current phase.

Top module: `stopclk_ctrl`

## Requirements
- R1: During and after reset, status is RUN (code 0), ack_req and resume are low, and every core_clk_en bit is high. bus_clk_en and intc_clk_en are high from the first clock edge after reset is released.
- R2: stop_req_n is asynchronous. ack_req rises, and status becomes ACK_PENDING (code 1), on the SYNC_STAGES+1-th rising clock edge after stop_req_n goes low.
- R3: ack_req stays high in every cycle until ack_done is sampled high.
- R4: Core clock enables stay high while the acknowledge is pending. On the edge that samples ack_done high with the request still asserted, ack_req falls, every core_clk_en bit falls, and status becomes STOP_GRANT (code 2).
- R5: Once high, bus_clk_en and intc_clk_en stay high in every state, including STOP_GRANT.
- R6: After stop_req_n returns high, every core_clk_en bit rises on the SYNC_STAGES+1-th rising edge, and status becomes EXITING (code 3) on that same edge.
- R7: EXITING lasts exactly EXIT_CYCLES cycles. Status then returns to RUN, and resume is high for exactly the first cycle of RUN.
- R8: If the request is withdrawn before ack_done arrives, ack_req stays high until ack_done. On that edge status goes straight to RUN, core_clk_en stays all high throughout, and resume stays low.
- R9: ack_done has no effect on status or on any output while status is RUN or STOP_GRANT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| ack_done | input | 1 | Bus interface reports that the acknowledge transaction was issued |
| ack_req | output | 1 | Request to issue the stop-grant acknowledge transaction |
| core_clk_en | output | NUM_CORE | Clock enables for the core units |
| bus_clk_en | output | 1 | Clock enable for the bus interface unit |
| intc_clk_en | output | 1 | Clock enable for the interrupt controller |
| resume | output | 1 | One-cycle pulse: execution may resume |
| status | output | 2 | 0 RUN, 1 ACK_PENDING, 2 STOP_GRANT, 3 EXITING |

## Verification
The assertions assume that ack_done is a one-cycle, synchronous handshake that the bus interface gives only in reply to ack_req. They also assume stop_req_n reaches the controller only through the synchroniser, so any edge of it is seen whole and never as a runt pulse. The stimulus drives stop_req_n and ack_done only at falling clock edges and holds every request level for longer than the synchroniser depth. It pulses ack_done in other states only to show that it is ignored there. The sweep varies the acknowledge delay and whether the request is withdrawn early.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_ACKWAIT = 2'd1,
      ST_GRANT   = 2'd2,
      ST_EXIT    = 2'd3
   } stc_state_e;
endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("stopclk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
   import stopclk_pkg::*;
#(
   parameter int EXIT_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       ack_done,
   output stc_state_e state,
   output logic       ack_req,
   output logic       core_on,
   output logic       resume
);
   localparam int CW = (EXIT_CYCLES > 1) ? $clog2(EXIT_CYCLES) : 1;

   generate
      if (EXIT_CYCLES < 1) begin : g_bad_exit
         $error("stopclk_fsm: EXIT_CYCLES must be at least 1");
      end
   endgenerate

   stc_state_e     st_q, st_d;
   logic [CW-1:0]  cnt_q;
   logic           ack_q, core_q, resume_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN:     if (req) st_d = ST_ACKWAIT;
         ST_ACKWAIT: if (ack_done) st_d = req ? ST_GRANT : ST_RUN;
         ST_GRANT:   if (!req) st_d = ST_EXIT;
         ST_EXIT:    if (cnt_q == '0) st_d = ST_RUN;
         default:    st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_RUN;
         cnt_q    <= '0;
         ack_q    <= 1'b0;
         core_q   <= 1'b1;
         resume_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         ack_q    <= (st_d == ST_ACKWAIT);
         core_q   <= (st_d != ST_GRANT);
         resume_q <= (st_q == ST_EXIT) && (st_d == ST_RUN);
         if (st_d == ST_EXIT && st_q != ST_EXIT)
            cnt_q <= CW'(EXIT_CYCLES - 1);
         else if (st_q == ST_EXIT && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign state   = st_q;
   assign ack_req = ack_q;
   assign core_on = core_q;
   assign resume  = resume_q;

   assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !ack_done) |=> ack_req);

   assert_grant_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACKWAIT && ack_done && req) |=> (st_q == ST_GRANT && !core_on && !ack_req));

   assert_grant_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GRANT && !req) |=> (st_q == ST_EXIT && core_on));

   assert_resume_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> !resume);

   assert_resume_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resume) |-> (st_q == ST_RUN && $past(st_q) == ST_EXIT));

   assert_withdraw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACKWAIT && ack_done && !req) |=> (st_q == ST_RUN && core_on && !resume));

   assert_ignore_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GRANT && req) |=> (st_q == ST_GRANT));
endmodule

// File: rtl/stopclk_enables.sv
module stopclk_enables #(
   parameter int NUM_CORE = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                core_on,
   output logic [NUM_CORE-1:0] core_en,
   output logic                bus_en,
   output logic                intc_en
);
   generate
      if (NUM_CORE < 1) begin : g_bad_units
         $error("stopclk_enables: NUM_CORE must be at least 1");
      end
      for (genvar u = 0; u < NUM_CORE; u++) begin : g_core
         assign core_en[u] = core_on;
      end
   endgenerate

   logic keep_q;

   always_ff @(posedge clk) begin
      if (!rst_n) keep_q <= 1'b0;
      else        keep_q <= 1'b1;
   end

   assign bus_en  = keep_q;
   assign intc_en = keep_q;

   assert_keep_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && intc_en) |=> (bus_en && intc_en));
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
   import stopclk_pkg::*;
#(
   parameter int NUM_CORE    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int EXIT_CYCLES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stop_req_n,
   input  logic                ack_done,
   output logic                ack_req,
   output logic [NUM_CORE-1:0] core_clk_en,
   output logic                bus_clk_en,
   output logic                intc_clk_en,
   output logic                resume,
   output logic [1:0]          status
);
   logic       req_n_sync;
   logic       core_on;
   stc_state_e state;

   stopclk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(stop_req_n), .dout(req_n_sync)
   );

   stopclk_fsm #(.EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(~req_n_sync), .ack_done(ack_done),
      .state(state), .ack_req(ack_req), .core_on(core_on), .resume(resume)
   );

   stopclk_enables #(.NUM_CORE(NUM_CORE)) u_en (
      .clk(clk), .rst_n(rst_n), .core_on(core_on),
      .core_en(core_clk_en), .bus_en(bus_clk_en), .intc_en(intc_clk_en)
   );

   assign status = state;

   assert_core_off_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (core_clk_en != {NUM_CORE{1'b1}}) |-> (status == 2'd2));

   assert_grant_keeps_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'd2) |-> (bus_clk_en && intc_clk_en));
endmodule

// File: tb/sim_stopclk_ctrl.sv
`timescale 1ns/100ps
module sim_stopclk_ctrl;
   localparam int NC = 4, SS = 2, EX = 3;

   logic clk = 1'b0, rst_n = 1'b0, stop_req_n = 1'b1, ack_done = 1'b0;
   logic ack_req, bus_clk_en, intc_clk_en, resume;
   logic [NC-1:0] core_clk_en;
   logic [1:0] status;
   int errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   stopclk_ctrl #(.NUM_CORE(NC), .SYNC_STAGES(SS), .EXIT_CYCLES(EX)) u0 (
      .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .ack_done(ack_done),
      .ack_req(ack_req), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
      .intc_clk_en(intc_clk_en), .resume(resume), .status(status)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic run_one(input int dly, input bit withdraw);
      int k;
      stop_req_n = 1'b0;
      for (k = 1; k <= 10; k++) begin cyc(); if (ack_req) break; end
      chk(k == SS + 1, "R2 ack latency", k, SS + 1);
      chk(status == 2'd1, "R2 status ACK_PENDING", status, 1);
      for (int d = 0; d < dly; d++) begin
         cyc();
         chk(ack_req == 1'b1, "R3 ack held", ack_req, 1);
         chk(core_clk_en == '1, "R4 core on while pending", core_clk_en, 15);
      end
      if (withdraw) begin
         stop_req_n = 1'b1;
         for (int d = 0; d < SS + 1; d++) begin
            cyc();
            chk(ack_req == 1'b1 && core_clk_en == '1, "R8 ack held after withdraw", ack_req, 1);
         end
         ack_done = 1'b1; cyc(); ack_done = 1'b0;
         chk(status == 2'd0, "R8 direct RUN", status, 0);
         chk(ack_req == 1'b0 && resume == 1'b0, "R8 no ack no resume", {ack_req, resume}, 0);
         cyc();
         chk(core_clk_en == '1 && resume == 1'b0, "R8 core stays on", core_clk_en, 15);
      end else begin
         ack_done = 1'b1; cyc(); ack_done = 1'b0;
         chk(status == 2'd2, "R4 STOP_GRANT", status, 2);
         chk(core_clk_en == '0 && ack_req == 1'b0, "R4 core off ack low", core_clk_en, 0);
         chk(bus_clk_en && intc_clk_en, "R5 bus/intc on in grant", {bus_clk_en, intc_clk_en}, 3);
         ack_done = 1'b1; cyc(); ack_done = 1'b0; cyc();
         chk(status == 2'd2 && core_clk_en == '0, "R9 done ignored in grant", status, 2);
         stop_req_n = 1'b1;
         for (k = 1; k <= 10; k++) begin cyc(); if (status != 2'd2) break; end
         chk(k == SS + 1, "R6 exit latency", k, SS + 1);
         chk(status == 2'd3 && core_clk_en == '1, "R6 EXITING core on", status, 3);
         for (k = 1; k <= 10; k++) begin cyc(); if (status == 2'd0) break; end
         chk(k == EX, "R7 exit length", k, EX);
         chk(resume == 1'b1, "R7 resume pulse", resume, 1);
         cyc();
         chk(resume == 1'b0, "R7 resume one cycle", resume, 0);
      end
      cyc();
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      @(negedge clk); cyc(); cyc();
      chk(status == 2'd0 && ack_req == 1'b0 && resume == 1'b0, "R1 reset outputs", status, 0);
      chk(core_clk_en == '1, "R1 reset core on", core_clk_en, 15);
      rst_n = 1'b1; cyc();
      chk(bus_clk_en && intc_clk_en, "R1 bus/intc on", {bus_clk_en, intc_clk_en}, 3);
      ack_done = 1'b1; cyc(); ack_done = 1'b0; cyc();
      chk(status == 2'd0 && ack_req == 1'b0 && core_clk_en == '1, "R9 done ignored in RUN", status, 0);
      for (int d = 0; d < 5; d++)
         for (int w = 0; w < 2; w++)
            run_one(d, w[0]);
      chk(bus_clk_en && intc_clk_en, "R5 bus/intc still on", {bus_clk_en, intc_clk_en}, 3);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule